// File: doc/BRIEF.md
# Serial Port Register and Interrupt Block

This block is the register front end of a simple serial port. It sits on a 32-bit, word-addressed bus and holds three control words, a transmit data word, a status word with two read views, and a small interrupt unit. It converts bus writes of the data word into bytes on a transmit stream, which has a one-cycle valid strobe. It accepts bytes from a receive stream and stores them in the status word. It raises one interrupt line from the raw event bits after they are filtered through a mask.

Bit serialisation, baud timing, DMA and queues belong to the neighbouring logic. The transmit status bits therefore always read as ready and idle. Software reads a received byte through the clearing view of the status word, which drops the data-available flag. It can look at the word through the other view without disturbing it. Software clears events by writing ones to the acknowledge word.

Top module: `sio_regfile`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x01400000 (bit 24 transmitter ready = 1, bit 22 transmitter idle = 1, bit 16 data-available = 0, bits 7:0 = 0). The control, mask and raw words read 0, and irq_out and tx_valid are low.
- R2: The words at byte offsets 0x00, 0x04, 0x08 (receive control) and 0x2C (mask) read back the full 32-bit value last written. Address bits 1:0 are ignored, so the word index is bus_addr shifted right by 2.
- R3: A write at 0x1C stores the value, which then reads back. In the next cycle tx_valid is high for exactly one cycle, with tx_byte equal to bits 7:0 of the written data. The write also sets raw event bit 0.
- R4: A byte is accepted in a cycle where rx_valid and rx_ready are both high. It replaces status bits 7:0, sets status bit 16 and sets raw event bit 3. The raw word is read at 0x34.
- R5: A read at 0x20 returns the current status word and clears bit 16 at the end of that cycle. A read at 0x24 returns the same word and changes nothing.
- R6: Writing at 0x30 clears every raw bit written as one. Reads at 0x30 return 0. When an event sets a bit in the same cycle that the bit is acknowledged, the set wins.
- R7: The word at 0x38 equals raw AND mask. irq_out is high exactly when that word is nonzero, and it follows each write or receive by one clock edge.
- R8: rx_ready is high when receive-control bit 0 is one or raw bit 3 is zero. When rx_ready is low, an offered byte is dropped and the status word does not change.
- R9: A clearing read at 0x20 in the same cycle that a byte is accepted returns the old word. Afterwards bit 16 is set and bits 7:0 hold the new byte.
- R10: Offsets 0x0C to 0x18, 0x28 and 0x3C and above read 0, and writes there change nothing. Writes to 0x20, 0x24, 0x34 and 0x38 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| tx_valid | output | 1 | One-cycle strobe for a transmit byte |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be accepted |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest case to produce is a clearing status read that coincides with an accepted byte, because a clear and a set then act on the same flag at one edge. The bench first sets receive-control bit 0 so that rx_ready stays high while raw bit 3 is still pending. It then drives rx_valid in the very cycle that carries the read at 0x20. The same method, an event in the same cycle as an acknowledge, checks that a set wins over a clear on raw bit 3. It also checks that an offered byte is dropped while rx_ready is low.

// File: rtl/sio_pkg.sv
// Shared constants and the register-select type for the serial port register block.
// Assumes a 32-bit data bus and byte addresses aligned to words.
package sio_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    // Byte offsets: software depends on them
    localparam int OFF_TXCTL  = 'h00;
    localparam int OFF_DMAEN  = 'h04;
    localparam int OFF_RXCTL  = 'h08;
    localparam int OFF_DOUT   = 'h1C;
    localparam int OFF_STATRC = 'h20;
    localparam int OFF_STATRO = 'h24;
    localparam int OFF_MASK   = 'h2C;
    localparam int OFF_ACK    = 'h30;
    localparam int OFF_RAW    = 'h34;
    localparam int OFF_MSKD   = 'h38;
    localparam int SPAN       = 'h3C;

    // Status word and event bit positions
    localparam int BIT_DAV     = 16;
    localparam int BIT_TX_IDLE = 22;
    localparam int BIT_TX_RDY  = 24;
    localparam int EV_TX       = 0;
    localparam int EV_RX       = 3;

    typedef enum logic [3:0] {
        SEL_TXCTL, SEL_DMAEN, SEL_RXCTL, SEL_DOUT, SEL_STATRC,
        SEL_STATRO, SEL_MASK, SEL_ACK, SEL_RAW, SEL_MSKD, SEL_NONE
    } sio_sel_e;
endpackage

// File: rtl/sio_addr_dec.sv
// Maps a word index to a register select. Indices at or beyond the
// decoded span, and holes inside it, give SEL_NONE.
module sio_addr_dec
    import sio_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] word_idx,
    output sio_sel_e         sel
);
    int off;

    // Pure combinational decode of the byte offset
    always_comb begin
        off = int'({word_idx, 2'b00});
        sel = SEL_NONE;
        if (off < SPAN) begin
            case (off)
                OFF_TXCTL:  sel = SEL_TXCTL;
                OFF_DMAEN:  sel = SEL_DMAEN;
                OFF_RXCTL:  sel = SEL_RXCTL;
                OFF_DOUT:   sel = SEL_DOUT;
                OFF_STATRC: sel = SEL_STATRC;
                OFF_STATRO: sel = SEL_STATRO;
                OFF_MASK:   sel = SEL_MASK;
                OFF_ACK:    sel = SEL_ACK;
                OFF_RAW:    sel = SEL_RAW;
                OFF_MSKD:   sel = SEL_MSKD;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sio_rx_status.sv
// Holds the last received byte and the data-available flag, and builds
// the status word. When a byte is taken in the same cycle as a clear,
// the take wins. The transmitter is assumed to be always ready and idle.
module sio_rx_status
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              clr_dav,
    output logic              dav,
    output logic [WORD_W-1:0] word
);
    logic [BYTE_W-1:0] data_q;

    // Capture the byte and update the flag, with set before clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dav    <= 1'b0;
        end else begin
            if (take) data_q <= byte_in;
            if (take)         dav <= 1'b1;
            else if (clr_dav) dav <= 1'b0;
        end
    end

    // Assemble the status word from its fields
    always_comb begin
        word              = '0;
        word[BYTE_W-1:0]  = data_q;
        word[BIT_DAV]     = dav;
        word[BIT_TX_IDLE] = 1'b1;
        word[BIT_TX_RDY]  = 1'b1;
    end
endmodule

// File: rtl/sio_irq_ctl.sv
// Raw event bits with write-one-to-clear, an interrupt mask and the
// output line. A new event beats an acknowledge of the same bit.
module sio_irq_ctl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic         irq
);
    logic [W-1:0] ack_bits;

    // Bits to clear this cycle
    always_comb ack_bits = ack_we ? wdata : '0;

    // Update raw events and the mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~ack_bits) | set_vec;
            if (mask_we) mask <= wdata;
        end
    end

    // Filter the events and reduce them to one line
    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end
endmodule

// File: rtl/sio_regfile.sv
// Top of the serial port register block: control words, data out, the
// status views, the interrupt unit and the byte streams. Reads are
// combinational. Writes and read side effects take effect at the clock edge.
module sio_regfile
    import sio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              irq_out
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int N_CTL  = 3;
    localparam sio_sel_e CTL_MAP [N_CTL] = '{SEL_TXCTL, SEL_DMAEN, SEL_RXCTL};

    sio_sel_e                     sel;
    logic                         wr_en, rd_en, rx_take, dav_w, unused_lsb;
    logic [N_CTL-1:0][WORD_W-1:0] ctl_w;
    logic [WORD_W-1:0]            dout_q, stat_w, raw_w, mask_w, mskd_w, set_vec;

    assign unused_lsb = ^bus_addr[1:0];
    assign wr_en      = bus_sel && bus_wr;
    assign rd_en      = bus_sel && !bus_wr;

    sio_addr_dec #(.IDX_W(IDX_W)) u_dec (
        .word_idx (bus_addr[ADDR_W-1:2]),
        .sel      (sel)
    );

    // One plain read/write control word per map entry
    for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                            q <= '0;
            else if (wr_en && sel == CTL_MAP[g])   q <= bus_wdata;
        end
        assign ctl_w[g] = q;
    end

    // Data-out word and the transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q   <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= wr_en && sel == SEL_DOUT;
            if (wr_en && sel == SEL_DOUT) begin
                dout_q  <= bus_wdata;
                tx_byte <= bus_wdata[BYTE_W-1:0];
            end
        end
    end

    // Receive handshake and event sources
    always_comb begin
        rx_ready       = ctl_w[2][0] || !raw_w[EV_RX];
        rx_take        = rx_valid && rx_ready;
        set_vec        = '0;
        set_vec[EV_TX] = wr_en && sel == SEL_DOUT;
        set_vec[EV_RX] = rx_take;
    end

    sio_rx_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (rx_take),
        .byte_in (rx_byte),
        .clr_dav (rd_en && sel == SEL_STATRC),
        .dav     (dav_w),
        .word    (stat_w)
    );

    sio_irq_ctl #(.W(WORD_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr_en && sel == SEL_MASK),
        .ack_we  (wr_en && sel == SEL_ACK),
        .wdata   (bus_wdata),
        .set_vec (set_vec),
        .raw     (raw_w),
        .mask    (mask_w),
        .masked  (mskd_w),
        .irq     (irq_out)
    );

    // Read multiplexer; unmapped and acknowledge offsets give zero
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_TXCTL:              bus_rdata = ctl_w[0];
                SEL_DMAEN:              bus_rdata = ctl_w[1];
                SEL_RXCTL:              bus_rdata = ctl_w[2];
                SEL_DOUT:               bus_rdata = dout_q;
                SEL_STATRC, SEL_STATRO: bus_rdata = stat_w;
                SEL_MASK:               bus_rdata = mask_w;
                SEL_RAW:                bus_rdata = raw_w;
                SEL_MSKD:               bus_rdata = mskd_w;
                default:                bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sio_regfile_chk.sv
// Temporal checks for sio_regfile, attached with bind. It decodes the bus
// on its own and watches the raw bits, the flag and the receive control.
module sio_regfile_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              irq_out,
    input logic              raw0,
    input logic              raw3,
    input logic              dav,
    input logic              rxctl0
);
    logic [ADDR_W-1:0] boff;
    logic hit_dout, hit_rc, hit_ack, hit_mask, hit_rxctl, take;

    // Own decode of the accesses that matter
    always_comb begin
        boff      = {bus_addr[ADDR_W-1:2], 2'b00};
        hit_dout  = bus_sel && bus_wr  && boff == ADDR_W'('h1C);
        hit_rc    = bus_sel && !bus_wr && boff == ADDR_W'('h20);
        hit_ack   = bus_sel && bus_wr  && boff == ADDR_W'('h30);
        hit_mask  = bus_sel && bus_wr  && boff == ADDR_W'('h2C);
        hit_rxctl = bus_sel && bus_wr  && boff == ADDR_W'('h08);
        take      = rx_valid && rx_ready;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tx_valid && !irq_out);
    assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_dout |=> tx_valid && tx_byte == $past(bus_wdata[7:0]));
    assert_tx_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(hit_dout));
    assert_rx_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> raw3);
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rc && !take |=> !dav);
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ack && bus_wdata[0] |=> !raw0);
    assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mask && bus_wdata == 32'h0 |=> !irq_out);
    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take && !rxctl0 && !hit_rxctl |=> !rx_ready);
    assert_take_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> dav);
endmodule

bind sio_regfile sio_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .irq_out   (irq_out),
    .raw0      (raw_w[0]),
    .raw3      (raw_w[3]),
    .dav       (dav_w),
    .rxctl0    (ctl_w[2][0])
);

// File: tb/tb_sio_regfile.sv
// Bench for sio_regfile: a table of bus vectors walked by one loop,
// then directed tests for the streams, interrupts and corner cases.
module tb_sio_regfile;
    localparam int ADDR_W = 8;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h24, 32'h0140_0000, 4'd1},  // R1 status at reset
        '{1'b0, 8'h20, 32'h0140_0000, 4'd1},  // R1 clearing view, same word
        '{1'b0, 8'h34, 32'h0,         4'd1},  // R1 raw
        '{1'b0, 8'h2C, 32'h0,         4'd1},  // R1 mask
        '{1'b1, 8'h00, 32'hA5A5_0001, 4'd2},
        '{1'b0, 8'h00, 32'hA5A5_0001, 4'd2},  // R2
        '{1'b1, 8'h06, 32'h0000_0003, 4'd2},  // R2 low bits ignored -> 0x04
        '{1'b0, 8'h04, 32'h0000_0003, 4'd2},
        '{1'b1, 8'h2C, 32'h0000_0009, 4'd2},
        '{1'b0, 8'h2C, 32'h0000_0009, 4'd2},
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 4'd10},
        '{1'b0, 8'h0C, 32'h0,         4'd10}, // R10 hole
        '{1'b1, 8'h40, 32'h1234_5678, 4'd10},
        '{1'b0, 8'h00, 32'hA5A5_0001, 4'd10}, // R10 out-of-span write ignored
        '{1'b0, 8'h28, 32'h0,         4'd10},
        '{1'b0, 8'h3C, 32'h0,         4'd10},
        '{1'b1, 8'h34, 32'h0000_000F, 4'd10},
        '{1'b0, 8'h34, 32'h0,         4'd10}, // R10 raw read-only
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 4'd6},
        '{1'b0, 8'h30, 32'h0,         4'd6},  // R6 ack reads zero
        '{1'b1, 8'h24, 32'h0,         4'd10},
        '{1'b0, 8'h24, 32'h0140_0000, 4'd10}, // R10 status read-only
        '{1'b1, 8'h38, 32'h0000_000F, 4'd10},
        '{1'b0, 8'h38, 32'h0,         4'd10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              tx_valid, rx_ready, irq_out;
    logic [7:0]        tx_byte;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic [31:0]       rd_cap;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sio_regfile #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .irq_out(irq_out)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d act=%h exp=%h", req, act, exp);
        end
    endtask

    // One bus cycle, optionally with a receive offer; read data captured
    task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic rv, input logic [7:0] rb);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_byte = rb;
        #2 rd_cap = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, a, d, 1'b0, 8'h0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
        op(1'b0, a, 32'h0, 1'b0, 8'h0);
        check(req, rd_cap, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        check(1, {30'h0, irq_out, tx_valid}, 32'h0);   // R1 outputs quiet

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else           rd(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        end

        // R3 transmit path (mask is 0x9)
        wr(8'h1C, 32'h1234_56C3);
        idle();
        check(3, {23'h0, tx_valid, tx_byte}, {23'h0, 1'b1, 8'hC3});
        idle();
        check(3, {31'h0, tx_valid}, 32'h0);            // R3 single pulse
        rd(8'h1C, 32'h1234_56C3, 3);
        rd(8'h34, 32'h1, 3);
        rd(8'h38, 32'h1, 7);
        idle();
        check(7, {31'h0, irq_out}, 32'h1);             // R7 line high

        // R7 mask off then back on
        wr(8'h2C, 32'h0); idle();
        check(7, {31'h0, irq_out}, 32'h0);
        rd(8'h38, 32'h0, 7);
        wr(8'h2C, 32'h9); idle();
        check(7, {31'h0, irq_out}, 32'h1);

        // R6 acknowledge bit 0
        wr(8'h30, 32'h1); idle();
        check(7, {31'h0, irq_out}, 32'h0);
        rd(8'h34, 32'h0, 6);

        // R4 receive, R8 handshake
        idle();
        check(8, {31'h0, rx_ready}, 32'h1);
        op(1'b0, 8'h00, 32'h0, 1'b1, 8'h5A);
        idle();
        check(8, {31'h0, rx_ready}, 32'h0);
        check(7, {31'h0, irq_out}, 32'h1);
        rd(8'h34, 32'h8, 4);
        rd(8'h24, 32'h0141_005A, 4);
        rd(8'h24, 32'h0141_005A, 5);                   // R5 no side effect
        rd(8'h20, 32'h0141_005A, 5);
        rd(8'h24, 32'h0140_005A, 5);                   // R5 flag cleared

        // R8 offered byte dropped while not ready
        op(1'b0, 8'h00, 32'h0, 1'b1, 8'h11);
        idle();
        rd(8'h24, 32'h0140_005A, 8);
        wr(8'h08, 32'h1); idle();
        check(8, {31'h0, rx_ready}, 32'h1);

        // R9 clearing read coincides with accepted byte
        op(1'b0, 8'h20, 32'h0, 1'b1, 8'h77);
        check(9, rd_cap, 32'h0140_005A);
        rd(8'h24, 32'h0141_0077, 9);

        // R6 set wins over acknowledge of the same bit
        op(1'b1, 8'h30, 32'h8, 1'b1, 8'h42);
        rd(8'h34, 32'h8, 6);
        rd(8'h24, 32'h0141_0042, 4);
        wr(8'h30, 32'h8);
        rd(8'h34, 32'h0, 6);

        // R1 reset mid-run
        do_reset();
        rd(8'h24, 32'h0140_0000, 1);
        rd(8'h08, 32'h0, 1);
        rd(8'h2C, 32'h0, 1);
        idle();
        check(1, {30'h0, irq_out, tx_valid}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule